// File: doc/BRIEF.md
# Budgeted Fixed-Priority Bus Reservation Controller

This controller decides which of several DMA-capable peripheral bridges may move data over a shared memory bus. Only one of them may do so at any moment. Each bridge reports through a data-ready line that it holds buffered data. The controller answers on a per-bridge block line, and a bridge moves data only while its block line is low. The bus is therefore scheduled like tasks on a single processor.

Each flow has its own budget server. A server turns its own data-ready line into an eligibility signal, and it works only from that line and its own budget, period and replenishment state. The server charges one budget tick for every cycle its flow is granted. The amount consumed in one continuous burst is returned one period after that burst began, which is the sporadic-server rule. Each server keeps a short queue of these pending returns. A fixed-priority chain grants the lowest-numbered eligible flow. The integrator assigns ports in rate-monotonic order, so the flow with the shortest period goes on port 0. A configuration write sets a flow's budget and period. When the global enable is low, every block line is driven low and the bridges contend freely.

Top module: `bus_resv_ctrl`

## Requirements
- R1: After reset all budgets are zero, so every block line reads high while the controller is enabled, even with data-ready asserted.
- R2: While enabled, at most one block line is low in any cycle.
- R3: When several flows are eligible, the flow with the lowest port index is granted (port 0 has the highest priority).
- R4: block is registered: a change on data-ready appears on block at the first rising clock edge after the change, and not before.
- R5: A flow whose data-ready was low in the previous cycle is never unblocked.
- R6: A flow with budget B and data-ready held high, with no higher-priority competitor, is unblocked for exactly B consecutive cycles and is then blocked.
- R7: The amount a flow consumed in one continuous grant burst is added back to its budget exactly P clock edges after the edge on which that burst began, where P is the flow's period. The flow can be unblocked again from the following edge.
- R8: When enable is low, every block line is low from the next clock edge. When enable returns high, block again follows the schedule from the next edge. No budget is charged while the controller is disabled.
- R9: A configuration write loads the flow's budget to full, sets its period and discards its pending replenishments. A period of zero is treated as one.
- R10: A flow whose replenishment queue has no free slot, and which is not in the middle of a burst, is not eligible even when its budget is nonzero.
- R11: A flow preempted by a higher-priority flow keeps its unspent budget. Its total granted cycles still equal its budget.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_enable | input | 1 | High: schedule enforced; low: all block lines low |
| data_rdy | input | N_FLOWS | Per-flow data-ready from each bridge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_flow | input | IDX_W | Flow index for the configuration write |
| cfg_budget | input | CNT_W | Budget in clock ticks |
| cfg_period | input | CNT_W | Period in clock ticks |
| block | output | N_FLOWS | Per-flow block line, registered |

## Verification
The bench builds the block with four flows, 12-bit counters and a replenishment queue of depth two. The shallow queue lets a flow run out of slots after only two short bursts, so the no-free-slot case is reached within a few dozen cycles. The small periods (10 to 200 ticks) put the replenishment edge at a cycle that can be checked exactly. With four flows the bench can also show preemption between two flows while the other two stay idle.

// File: rtl/bus_resv_pkg.sv
package bus_resv_pkg;
  localparam int unsigned DEF_FLOWS   = 4;
  localparam int unsigned DEF_CNT_W   = 24;
  localparam int unsigned DEF_RQ_DEPTH = 4;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bus_resv_server.sv
module bus_resv_server
  import bus_resv_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned RQ_DEPTH = DEF_RQ_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_rdy,
  input  logic             exec,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_budget,
  input  logic [CNT_W-1:0] cfg_period,
  output logic             ready,
  output logic             budget_zero
);
  localparam int unsigned SLOT_W = idx_width(RQ_DEPTH);

  logic [CNT_W-1:0]  budget_q, budget_d;
  logic [CNT_W-1:0]  period_q, period_d;
  logic              burst_q, burst_d;
  logic [SLOT_W-1:0] cur_q, cur_d;
  logic [RQ_DEPTH-1:0] vld_q, vld_d;
  logic [CNT_W-1:0]  cnt_q [RQ_DEPTH];
  logic [CNT_W-1:0]  cnt_d [RQ_DEPTH];
  logic [CNT_W-1:0]  amt_q [RQ_DEPTH];
  logic [CNT_W-1:0]  amt_d [RQ_DEPTH];

  logic [RQ_DEPTH-1:0] hit;
  logic [CNT_W-1:0]  rep_sum;
  logic              free_any;
  logic [SLOT_W-1:0] free_idx;
  logic              start;
  logic              cur_hit;

  // free slot search and due replenishments
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    rep_sum  = '0;
    cur_hit  = 1'b0;
    for (int d = RQ_DEPTH - 1; d >= 0; d--) begin
      if (!vld_q[d]) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(d);
      end
    end
    for (int d = 0; d < RQ_DEPTH; d++) begin
      hit[d] = vld_q[d] && (cnt_q[d] == CNT_W'(1));
      if (hit[d]) rep_sum = rep_sum + amt_q[d];
      if (hit[d] && (SLOT_W'(d) == cur_q)) cur_hit = 1'b1;
    end
  end

  assign budget_zero = (budget_q == '0);
  assign ready = data_rdy && !budget_zero && (burst_q || free_any);
  assign start = exec && !burst_q;

  // next state
  always_comb begin
    budget_d = budget_q - {{(CNT_W-1){1'b0}}, exec} + rep_sum;
    period_d = period_q;
    cur_d    = start ? free_idx : cur_q;
    if (start)
      burst_d = 1'b1;
    else if (burst_q && (!exec || cur_hit))
      burst_d = 1'b0;
    else
      burst_d = burst_q;
    for (int d = 0; d < RQ_DEPTH; d++) begin
      vld_d[d] = vld_q[d];
      cnt_d[d] = cnt_q[d];
      amt_d[d] = amt_q[d];
      if (hit[d]) begin
        vld_d[d] = 1'b0;
      end else if (vld_q[d]) begin
        cnt_d[d] = cnt_q[d] - CNT_W'(1);
        if (exec && burst_q && (SLOT_W'(d) == cur_q))
          amt_d[d] = amt_q[d] + CNT_W'(1);
      end
      if (start && (SLOT_W'(d) == free_idx)) begin
        vld_d[d] = 1'b1;
        cnt_d[d] = period_q;
        amt_d[d] = CNT_W'(1);
      end
    end
    if (cfg_load) begin
      budget_d = cfg_budget;
      period_d = (cfg_period == '0) ? CNT_W'(1) : cfg_period;
      burst_d  = 1'b0;
      cur_d    = '0;
      vld_d    = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      budget_q <= '0;
      period_q <= CNT_W'(1);
      burst_q  <= 1'b0;
      cur_q    <= '0;
      vld_q    <= '0;
    end else begin
      budget_q <= budget_d;
      period_q <= period_d;
      burst_q  <= burst_d;
      cur_q    <= cur_d;
      vld_q    <= vld_d;
    end
  end

  for (genvar g = 0; g < RQ_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
        amt_q[g] <= '0;
      end else begin
        cnt_q[g] <= cnt_d[g];
        amt_q[g] <= amt_d[g];
      end
    end
  end
endmodule

// File: rtl/bus_resv_prio.sv
module bus_resv_prio #(
  parameter int unsigned N_FLOWS = 4
) (
  input  logic               enable,
  input  logic [N_FLOWS-1:0] ready,
  output logic [N_FLOWS-1:0] exec
);
  logic [N_FLOWS:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N_FLOWS; i++) begin : g_chain
    assign exec[i]    = enable && ready[i] && !taken[i];
    assign taken[i+1] = taken[i] || ready[i];
  end
endmodule

// File: rtl/bus_resv_outreg.sv
module bus_resv_outreg #(
  parameter int unsigned N_FLOWS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [N_FLOWS-1:0] exec,
  output logic [N_FLOWS-1:0] block
);
  logic [N_FLOWS-1:0] block_d;

  always_comb begin
    block_d = enable ? ~exec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) block <= '1;
    else        block <= block_d;
  end
endmodule

// File: rtl/bus_resv_ctrl.sv
module bus_resv_ctrl
  import bus_resv_pkg::*;
#(
  parameter int unsigned N_FLOWS  = DEF_FLOWS,
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned RQ_DEPTH = DEF_RQ_DEPTH,
  localparam int unsigned IDX_W   = idx_width(N_FLOWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_enable,
  input  logic [N_FLOWS-1:0] data_rdy,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_flow,
  input  logic [CNT_W-1:0]   cfg_budget,
  input  logic [CNT_W-1:0]   cfg_period,
  output logic [N_FLOWS-1:0] block
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [N_FLOWS-1:0] ready_vec;
  logic [N_FLOWS-1:0] zero_vec;
  logic [N_FLOWS-1:0] exec_vec;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar i = 0; i < N_FLOWS; i++) begin : g_srv
    logic load;
    assign load = cfg_we && (cfg_flow == IDX_W'(i));
    bus_resv_server #(.CNT_W(CNT_W), .RQ_DEPTH(RQ_DEPTH)) u_srv (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .data_rdy   (data_rdy[i]),
      .exec       (exec_vec[i]),
      .cfg_load   (load),
      .cfg_budget (cfg_budget),
      .cfg_period (cfg_period),
      .ready      (ready_vec[i]),
      .budget_zero(zero_vec[i])
    );
  end

  bus_resv_prio #(.N_FLOWS(N_FLOWS)) u_prio (
    .enable(ctl_enable),
    .ready (ready_vec),
    .exec  (exec_vec)
  );

  bus_resv_outreg #(.N_FLOWS(N_FLOWS)) u_out (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .enable(ctl_enable),
    .exec  (exec_vec),
    .block (block)
  );
endmodule

// File: rtl/bus_resv_ctrl_chk.sv
module bus_resv_ctrl_chk #(
  parameter int unsigned N_FLOWS = 4
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               ctl_enable,
  input logic [N_FLOWS-1:0] data_rdy,
  input logic [N_FLOWS-1:0] block,
  input logic [N_FLOWS-1:0] ready,
  input logic [N_FLOWS-1:0] budget_zero
);
  logic armed;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && $past(ctl_enable)) |-> ($countones(~block) <= 1));

  assert_bypass_low_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && !$past(ctl_enable)) |-> (block == '0));

  assert_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && $past(ctl_enable)) |-> (((~block) & ~$past(data_rdy)) == '0));

  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && $past(ctl_enable) && ((~block) != '0)) |->
      (($past(ready) & ((~block) - N_FLOWS'(1))) == '0));

  assert_no_empty_grant_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && $past(ctl_enable)) |-> (((~block) & $past(budget_zero)) == '0));
endmodule

bind bus_resv_ctrl bus_resv_ctrl_chk #(.N_FLOWS(N_FLOWS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ctl_enable (ctl_enable),
  .data_rdy   (data_rdy),
  .block      (block),
  .ready      (ready_vec),
  .budget_zero(zero_vec)
);

// File: tb/test_bus_resv_ctrl.sv
`timescale 1ns/1ps
module test_bus_resv_ctrl;
  localparam int unsigned NF = 4;
  localparam int unsigned CW = 12;
  localparam int unsigned RQ = 2;
  localparam int unsigned IW = 2;

  typedef struct {
    logic [NF-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_enable;
  logic [NF-1:0] data_rdy;
  logic          cfg_we;
  logic [IW-1:0] cfg_flow;
  logic [CW-1:0] cfg_budget;
  logic [CW-1:0] cfg_period;
  logic [NF-1:0] block;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  bit    live   = 1'b0;

  always #4 clk = ~clk;

  bus_resv_ctrl #(.N_FLOWS(NF), .CNT_W(CW), .RQ_DEPTH(RQ)) i_bus_resv_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .data_rdy(data_rdy),
    .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_budget(cfg_budget),
    .cfg_period(cfg_period), .block(block)
  );

  // driver: inputs at negedge, expected result queued for the next edge
  task automatic cyc(input logic [NF-1:0] rdy, input logic en,
                     input logic [NF-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    data_rdy   = rdy;
    ctl_enable = en;
    cfg_we     = 1'b0;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cfg(input int fl, input int b, input int p, input string tag);
    item_t it;
    @(negedge clk);
    data_rdy   = '0;
    ctl_enable = 1'b1;
    cfg_we     = 1'b1;
    cfg_flow   = IW'(fl);
    cfg_budget = CW'(b);
    cfg_period = CW'(p);
    it.exp = '1;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (live && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_run++;
        if (block !== it.exp) begin
          n_fail++;
          $display("FAIL %s: block actual %b expected %b at %0t", it.tag, block, it.exp, $time);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_enable = 1'b1; data_rdy = '0;
    cfg_we = 1'b0; cfg_flow = '0; cfg_budget = '0; cfg_period = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // R1: no budget yet, everything blocked
    repeat (2) cyc(4'b1111, 1'b1, 4'b1111, "R1");

    cfg(0, 3, 20, "R9");
    cfg(1, 5, 40, "R9");
    cfg(2, 2, 60, "R9");
    cfg(3, 4, 80, "R9");
    cyc(4'b0000, 1'b1, 4'b1111, "R5");

    // R6: flow1 alone, budget 5 (c1..c7)
    repeat (5) cyc(4'b0010, 1'b1, 4'b1101, "R6");
    repeat (2) cyc(4'b0010, 1'b1, 4'b1111, "R6");
    // R3: flow0 beats flow1 (c8..c12)
    repeat (3) cyc(4'b0011, 1'b1, 4'b1110, "R3");
    repeat (2) cyc(4'b0011, 1'b1, 4'b1111, "R6");
    // R4/R11: flow3 runs, flow2 preempts, flow3 resumes (c13..c20)
    cyc(4'b1000, 1'b1, 4'b0111, "R4");
    repeat (2) cyc(4'b1100, 1'b1, 4'b1011, "R11");
    repeat (3) cyc(4'b1100, 1'b1, 4'b0111, "R11");
    repeat (2) cyc(4'b1100, 1'b1, 4'b1111, "R11");
    // R7: flow1 burst began at c1, period 40 -> usable from c42
    repeat (20) cyc(4'b0000, 1'b1, 4'b1111, "R7");
    cyc(4'b0010, 1'b1, 4'b1111, "R7");
    repeat (5) cyc(4'b0010, 1'b1, 4'b1101, "R7");
    cyc(4'b0010, 1'b1, 4'b1111, "R7");

    // R10: two short bursts fill both slots of flow0
    cfg(0, 6, 200, "R9");
    cyc(4'b0001, 1'b1, 4'b1110, "R10");
    cyc(4'b0000, 1'b1, 4'b1111, "R10");
    cyc(4'b0001, 1'b1, 4'b1110, "R10");
    cyc(4'b0000, 1'b1, 4'b1111, "R10");
    repeat (2) cyc(4'b0001, 1'b1, 4'b1111, "R10");

    // R9: rewrite clears queue and refills budget
    cfg(0, 2, 10, "R9");
    repeat (2) cyc(4'b0001, 1'b1, 4'b1110, "R9");
    cyc(4'b0001, 1'b1, 4'b1111, "R9");

    // R8: bypass
    cyc(4'b1111, 1'b0, 4'b0000, "R8");
    cyc(4'b0000, 1'b0, 4'b0000, "R8");
    cyc(4'b0000, 1'b1, 4'b1111, "R8");

    // R7: flow0 burst began 10 edges before; returns then
    repeat (5) cyc(4'b0001, 1'b1, 4'b1111, "R7");
    repeat (2) cyc(4'b0001, 1'b1, 4'b1110, "R7");
    cyc(4'b0001, 1'b1, 4'b1111, "R7");

    cyc(4'b0000, 1'b1, 4'b1111, "R5");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule